// File: doc/BRIEF.md
# Flag-Based Relation Evaluator

This block decides whether a chosen relation between two operands A and B holds. It never sees the operands. It sees only the four status bits that an adder-subtractor produces while it computes A − B: overflow, carry-out, zero and negative. A 4-bit condition code picks one of ten relations. Six are signed or sign-neutral: equal, not equal, less, less-or-equal, greater-or-equal and greater. Four are unsigned: below, below-or-equal, at-or-above and above. The block returns one bit that says whether the chosen relation is true.

The subtractor is assumed to form A + ~B + 1. A carry-out of 1 therefore means no borrow took place. Signed ordering comes from negative XOR overflow, so the answer stays correct when the difference wraps. A parameter picks between a registered result (the default) and a purely combinational path. The registered form uses a synchronous, active-high reset.

Top module: `flag_cmp_eval`

## Requirements
- R1: Code 0 (equal) gives a result equal to the zero flag.
- R2: Code 1 (not equal) gives the complement of the zero flag.
- R3: Code 2 (signed less) gives negative XOR overflow.
- R4: Code 3 (signed less-or-equal) gives zero OR (negative XOR overflow).
- R5: Code 4 (signed greater-or-equal) gives the complement of (negative XOR overflow).
- R6: Code 5 (signed greater) gives the complement of (zero OR (negative XOR overflow)).
- R7: Code 6 (unsigned below) gives the complement of the carry flag, where carry is the carry-out of A + ~B + 1.
- R8: Code 7 (unsigned below-or-equal) gives (NOT carry) OR zero.
- R9: Code 8 (unsigned at-or-above) gives the carry flag.
- R10: Code 9 (unsigned above) gives carry AND NOT zero.
- R11: Codes 10 to 15 always give 0.
- R12: With the default registered build, the result reflects the flags and code sampled at the previous rising clock edge, with one cycle of latency.
- R13: While reset is high at a rising edge, the result becomes 0 regardless of the flags and the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| flag_v | input | 1 | Overflow from A − B |
| flag_c | input | 1 | Carry-out from A + ~B + 1 (1 = no borrow) |
| flag_z | input | 1 | Difference is zero |
| flag_n | input | 1 | Most significant bit of the difference |
| cond_sel | input | 4 | Relation code, 0 to 9 valid |
| holds | output | 1 | The selected relation is true |

## Verification
The bench derives the flags from 8-bit subtractions and compares each result with native signed and unsigned compares. It targets the following operand pairs:
- Operands that differ only in sign, such as 0x80 against 0x01 and 0x7F against 0x80. Here the overflow bit flips the signed answer, so a design that used the negative flag alone would report the wrong order.
- Equal operands, which expose any mix-up between the strict and the non-strict relations.
- Zero against all-ones, which separates the signed result from the unsigned one. Treating carry as a borrow would invert every unsigned result here.
- Codes 10 to 15, which must stay 0. A decoder that folded them onto valid codes would report true.
- A reset applied in the middle of traffic, which must clear a result that would otherwise be 1.

// File: rtl/flag_cmp_pkg.sv
package flag_cmp_pkg;
  localparam int SEL_W     = 4;
  localparam int NUM_CONDS = 10;

  typedef enum logic [SEL_W-1:0] {
    COND_EQ  = 4'd0,
    COND_NE  = 4'd1,
    COND_LT  = 4'd2,
    COND_LE  = 4'd3,
    COND_GE  = 4'd4,
    COND_GT  = 4'd5,
    COND_LTU = 4'd6,
    COND_LEU = 4'd7,
    COND_GEU = 4'd8,
    COND_GTU = 4'd9
  } cond_e;

  typedef struct packed {
    logic v;
    logic c;
    logic z;
    logic n;
  } flags_t;
endpackage

// File: rtl/flag_cmp_signed.sv
module flag_cmp_signed
  import flag_cmp_pkg::*;
(
  input  flags_t fl,
  output logic   lt,
  output logic   le,
  output logic   ge,
  output logic   gt
);
  logic order_neg;

  // wrap-corrected sign of the difference
  always_comb begin
    order_neg = fl.n ^ fl.v;
    lt        = order_neg;
    le        = order_neg | fl.z;
    ge        = ~order_neg;
    gt        = ~(order_neg | fl.z);
  end
endmodule

// File: rtl/flag_cmp_unsigned.sv
module flag_cmp_unsigned
  import flag_cmp_pkg::*;
(
  input  flags_t fl,
  output logic   ltu,
  output logic   leu,
  output logic   geu,
  output logic   gtu
);
  logic borrow;

  // carry-out of A + ~B + 1 is low exactly when a borrow occurred
  always_comb begin
    borrow = ~fl.c;
    ltu    = borrow;
    leu    = borrow | fl.z;
    geu    = ~borrow;
    gtu    = ~(borrow | fl.z);
  end
endmodule

// File: rtl/flag_cmp_select.sv
module flag_cmp_select #(
  parameter int N     = 10,
  parameter int SEL_W = 4
) (
  input  logic [N-1:0]     rel_vec,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign match[i] = (sel == i[SEL_W-1:0]) & rel_vec[i];
  end

  // codes with no matching slot leave every term low
  assign hit = |match;
endmodule

// File: rtl/flag_cmp_eval.sv
module flag_cmp_eval
  import flag_cmp_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_v,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             flag_n,
  input  logic [SEL_W-1:0] cond_sel,
  output logic             holds
);
  flags_t               fl;
  logic                 s_lt, s_le, s_ge, s_gt;
  logic                 u_lt, u_le, u_ge, u_gt;
  logic [NUM_CONDS-1:0] rel_vec;
  logic                 hit;

  assign fl = '{v: flag_v, c: flag_c, z: flag_z, n: flag_n};

  flag_cmp_signed u_signed (
    .fl (fl), .lt (s_lt), .le (s_le), .ge (s_ge), .gt (s_gt)
  );

  flag_cmp_unsigned u_unsigned (
    .fl (fl), .ltu (u_lt), .leu (u_le), .geu (u_ge), .gtu (u_gt)
  );

  // slot index equals the condition code
  always_comb begin
    rel_vec           = '0;
    rel_vec[COND_EQ]  = fl.z;
    rel_vec[COND_NE]  = ~fl.z;
    rel_vec[COND_LT]  = s_lt;
    rel_vec[COND_LE]  = s_le;
    rel_vec[COND_GE]  = s_ge;
    rel_vec[COND_GT]  = s_gt;
    rel_vec[COND_LTU] = u_lt;
    rel_vec[COND_LEU] = u_le;
    rel_vec[COND_GEU] = u_ge;
    rel_vec[COND_GTU] = u_gt;
  end

  flag_cmp_select #(.N(NUM_CONDS), .SEL_W(SEL_W)) u_select (
    .rel_vec (rel_vec), .sel (cond_sel), .hit (hit)
  );

  if (REGISTERED) begin : g_reg
    logic holds_q;
    always_ff @(posedge clk) begin
      if (rst) holds_q <= 1'b0;
      else     holds_q <= hit;
    end
    assign holds = holds_q;
  end else begin : g_comb
    assign holds = hit;
  end
endmodule

// File: rtl/flag_cmp_eval_chk.sv
module flag_cmp_eval_chk
  import flag_cmp_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             flag_v,
  input logic             flag_c,
  input logic             flag_z,
  input logic             flag_n,
  input logic [SEL_W-1:0] cond_sel,
  input logic             holds
);
  if (REGISTERED) begin : g_chk
    logic past_ok;
    always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
    end

    a_r1_eq: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd0) |-> holds == $past(flag_z));
    a_r2_ne: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd1) |-> holds != $past(flag_z));
    a_r3_lt: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd2) |-> holds == ($past(flag_n) != $past(flag_v)));
    a_r4_le: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd3 && $past(flag_z)) |-> holds);
    a_r5_ge: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd4) |-> holds == ($past(flag_n) == $past(flag_v)));
    a_r6_gt: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd5 && $past(flag_z)) |-> !holds);
    a_r7_ltu: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd6) |-> holds != $past(flag_c));
    a_r8_leu: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd7 && $past(flag_z)) |-> holds);
    a_r9_geu: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd8) |-> holds == $past(flag_c));
    a_r10_gtu: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) == 4'd9 && $past(flag_z)) |-> !holds);
    a_r11_unused: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(cond_sel) >= 4'd10) |-> !holds);
  end
endmodule

bind flag_cmp_eval flag_cmp_eval_chk #(.REGISTERED(REGISTERED)) u_chk (
  .clk (clk), .rst (rst), .flag_v (flag_v), .flag_c (flag_c),
  .flag_z (flag_z), .flag_n (flag_n), .cond_sel (cond_sel), .holds (holds)
);

// File: tb/flag_cmp_eval_tb_top.sv
`timescale 1ns/1ps
module flag_cmp_eval_tb_top;
  localparam int W = 8;

  typedef struct {
    logic        exp;
    logic [3:0]  code;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flag_v = 1'b0, flag_c = 1'b0, flag_z = 1'b0, flag_n = 1'b0;
  logic [3:0] cond_sel = 4'd0;
  logic       holds;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  flag_cmp_eval dut_i (
    .clk (clk), .rst (rst), .flag_v (flag_v), .flag_c (flag_c),
    .flag_z (flag_z), .flag_n (flag_n), .cond_sel (cond_sel), .holds (holds)
  );

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic ref_rel(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [3:0] c);
    case (c)
      4'd0: return a == b;
      4'd1: return a != b;
      4'd2: return $signed(a) <  $signed(b);
      4'd3: return $signed(a) <= $signed(b);
      4'd4: return $signed(a) >= $signed(b);
      4'd5: return $signed(a) >  $signed(b);
      4'd6: return a <  b;
      4'd7: return a <= b;
      4'd8: return a >= b;
      4'd9: return a >  b;
      default: return 1'b0;
    endcase
  endfunction

  // driver: build flags from A + ~B + 1 and queue the expected result
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    logic [W:0] full;
    item_t it;
    @(negedge clk);
    full     = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    flag_c   = full[W];
    flag_z   = (full[W-1:0] == '0);
    flag_n   = full[W-1];
    flag_v   = (a[W-1] != b[W-1]) && (full[W-1] != a[W-1]);
    cond_sel = c;
    it.exp = ref_rel(a, b, c); it.code = c; it.a = a; it.b = b;
    q.push_back(it);
  endtask

  task automatic all_codes(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int c = 0; c < 16; c++) drive(a, b, c[3:0]);
  endtask

  // monitor: one queued item per rising edge, R12 one-cycle latency
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (holds !== it.exp) begin
          errors++;
          $display("FAIL %s/R12 code=%0d a=%h b=%h actual=%b expected=%b",
                   tag_of(it.code), it.code, it.a, it.b, holds, it.exp);
        end
      end
    end
  end

  task automatic check_reset(input string what);
    checks++;
    if (holds !== 1'b0) begin
      errors++;
      $display("FAIL R13 %s actual=%b expected=0", what, holds);
    end
  endtask

  initial begin
    // R13: reset with inputs that would otherwise give 1 (EQ, zero set)
    flag_z = 1'b1; cond_sel = 4'd0;
    repeat (2) @(posedge clk);
    #1 check_reset("initial reset");
    @(negedge clk) rst = 1'b0;

    // corner pairs: equal, sign-boundary wrap, unsigned vs signed split
    all_codes(8'h00, 8'h00);
    all_codes(8'h80, 8'h01);
    all_codes(8'h7F, 8'h80);
    all_codes(8'h80, 8'h7F);
    all_codes(8'h00, 8'hFF);
    all_codes(8'hFF, 8'h00);
    all_codes(8'h80, 8'h80);
    all_codes(8'h01, 8'h02);
    all_codes(8'h7F, 8'hFF);

    for (int i = 0; i < 300; i++) all_codes($urandom(), $urandom());
    repeat (3) @(posedge clk);

    // R13: mid-run reset against a true EQ
    @(negedge clk);
    flag_z = 1'b1; cond_sel = 4'd0; rst = 1'b1;
    @(posedge clk);
    #1 check_reset("mid-run reset");
    @(negedge clk) rst = 1'b0;
    all_codes(8'h55, 8'h55);
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule